// File: doc/BRIEF.md
# Dual-Register Programmable Logic Output Cell

This block is one output cell of a sum-of-products programmable logic device. The AND array that builds the product terms sits outside the cell. The cell receives the terms already evaluated: twelve data terms arranged as three OR groups of four, plus one term each for the first register's clock and asynchronous clear, the second register's clock and asynchronous clear, and the pad output enable. It also receives the device's dedicated clock pin, a synchronous preset term shared with neighbouring cells, and the pad's input level.

Static configuration bits control the cell:
- how many data groups are merged into the first register's input;
- whether each register behaves as a D or a T flip-flop;
- whether each register's clock term is gated by the clock pin;
- whether the buried feedback carries the second register's output or its raw input;
- whether the pad shows the registered or the combinational value;
- the output polarity.

The cell returns three true/complement pairs to the global array: the buried feedback, the first register, and the pad input.

Top module: `pld_mcell`

## Requirements
- R1: Data group k is the OR of `pt_data[4k+3:4k]`. The first register's sum input takes group 0 when `cfg_sum`=0, groups 0 and 1 when `cfg_sum`=1, and all three groups when `cfg_sum` is 2 or 3.
- R2: The second register's sum input is always group 2. In the 12-term modes, that group also feeds the first register.
- R3: With its type bit at 0 (D type), a register loads its sum input on the rising edge of its effective clock.
- R4: With its type bit at 1 (T type), a register inverts on a rising edge of its effective clock when its sum input is 1, and holds when the sum input is 0.
- R5: With its pin-gate bit at 0, a register's effective clock is its own clock term. With the bit at 1, the effective clock is that term ANDed with `pin_clk`. Without a rising edge of its own effective clock, a register does not change.
- R6: Each register's clear term forces that register to 0 at once, with no clock, and leaves the other register untouched.
- R7: When `sync_preset` is 1 at an effective clock edge, the register loads 1, overriding both D data and toggling. An asserted clear term overrides the preset.
- R8: With `cfg_fb_raw`=0, the buried feedback is the second register's output. With `cfg_fb_raw`=1, it is the second register's sum input, passed through combinationally.
- R9: The pad value is the first register when `cfg_comb`=0, or the first register's sum input when `cfg_comb`=1. It leaves the cell unchanged when `cfg_act_high`=1 and inverted when `cfg_act_high`=0.
- R10: `pad_oe` equals the output-enable term `pt_oe` at all times.
- R11: Each feedback pair carries the true value and its complement. The pin pair is taken from `pad_in`.
- R12: `rst_n`=0 clears both registers. After reset, the pad reads 0 with `cfg_act_high`=1 and 1 with `cfg_act_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Power-up reset, active low, clears both registers |
| pin_clk | input | 1 | Dedicated device clock pin |
| pt_data | input | 12 | Data product terms, three groups of four |
| pt_ar1 | input | 1 | Asynchronous clear term, register 1 |
| pt_ck1 | input | 1 | Clock term, register 1 |
| pt_ck2 | input | 1 | Clock term, register 2 |
| pt_ar2 | input | 1 | Asynchronous clear term, register 2 |
| pt_oe | input | 1 | Output-enable term |
| sync_preset | input | 1 | Shared synchronous preset term |
| pad_in | input | 1 | Level seen on the pad |
| cfg_sum | input | 2 | Group-combine setting for register 1 |
| cfg_t1 | input | 1 | Register 1 type: 0 D, 1 T |
| cfg_t2 | input | 1 | Register 2 type: 0 D, 1 T |
| cfg_pin1 | input | 1 | Gate register 1 clock term with pin_clk |
| cfg_pin2 | input | 1 | Gate register 2 clock term with pin_clk |
| cfg_fb_raw | input | 1 | Buried feedback: 0 register 2, 1 its raw input |
| cfg_comb | input | 1 | Pad source: 0 register 1, 1 combinational sum |
| cfg_act_high | input | 1 | Output polarity: 1 true, 0 inverted |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable |
| fb_bur_t | output | 1 | Buried feedback, true |
| fb_bur_c | output | 1 | Buried feedback, complement |
| fb_q1_t | output | 1 | Register 1 feedback, true |
| fb_q1_c | output | 1 | Register 1 feedback, complement |
| fb_pin_t | output | 1 | Pad input feedback, true |
| fb_pin_c | output | 1 | Pad input feedback, complement |

## Verification
A wrong register state shows on `fb_q1_t`, and on `fb_bur_t` while the raw bypass is off, right after the effective clock edge that produced it. A stale value shows one edge late. A wrong toggle stays visible until the next edge or clear.

Steering faults are combinational. The bench therefore sweeps every data-term pattern under every combine setting, and any wrong group merge reaches `pad_out` or the buried pair within the same input change. Clock-source and clear faults show either as a change where no edge of that register's own clock occurred, or as no change at an edge that should have loaded.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    SUM_ONE   = 2'd0,
    SUM_TWO   = 2'd1,
    SUM_THREE = 2'd2,
    SUM_ALL   = 2'd3
  } sum_mode_e;

  // Next state of one storage cell at an effective clock edge.
  // Preset wins over data; the clear is handled asynchronously elsewhere.
  function automatic logic ff_next(input logic q, input logic din,
                                   input logic t_mode, input logic preset);
    logic nxt;
    if (preset)      nxt = 1'b1;
    else if (t_mode) nxt = q ^ din;
    else             nxt = din;
    return nxt;
  endfunction

endpackage

// File: rtl/mcell_sum_steer.sv
module mcell_sum_steer #(
  parameter int TERMS  = 4,
  parameter int GROUPS = 3,
  localparam int MODE_W = (GROUPS > 2) ? $clog2(GROUPS) : 1
) (
  input  logic [GROUPS*TERMS-1:0] pt,
  input  logic [MODE_W-1:0]       mode,
  output logic                    sum1,
  output logic                    sum2
);

  logic [GROUPS-1:0] grp;

  for (genvar g = 0; g < GROUPS; g++) begin : g_or
    assign grp[g] = |pt[g*TERMS +: TERMS];
  end

  // Register 1 absorbs groups 0..mode; register 2 always owns the last group.
  always_comb begin
    sum1 = 1'b0;
    for (int k = 0; k < GROUPS; k++) begin
      if (k <= int'(mode)) sum1 = sum1 | grp[k];
    end
  end

  assign sum2 = grp[GROUPS-1];

endmodule

// File: rtl/mcell_flop.sv
module mcell_flop (
  input  logic clk_term,
  input  logic pin_clk,
  input  logic pin_sel,
  input  logic arst,
  input  logic t_mode,
  input  logic preset,
  input  logic din,
  output logic clk_eff,
  output logic q
);
  import mcell_pkg::*;

  assign clk_eff = clk_term & (pin_sel ? pin_clk : 1'b1);

  always_ff @(posedge clk_eff or posedge arst) begin
    if (arst) q <= 1'b0;
    else      q <= ff_next(q, din, t_mode, preset);
  end

endmodule

// File: rtl/pld_mcell.sv
module pld_mcell #(
  parameter int TERMS_PER_SUM = 4,
  parameter int SUM_GROUPS    = 3,
  localparam int PT_W   = TERMS_PER_SUM * SUM_GROUPS,
  localparam int MODE_W = (SUM_GROUPS > 2) ? $clog2(SUM_GROUPS) : 1,
  localparam int N_REG  = 2
) (
  input  logic              rst_n,
  input  logic              pin_clk,
  input  logic [PT_W-1:0]   pt_data,
  input  logic              pt_ar1,
  input  logic              pt_ck1,
  input  logic              pt_ck2,
  input  logic              pt_ar2,
  input  logic              pt_oe,
  input  logic              sync_preset,
  input  logic              pad_in,
  input  logic [MODE_W-1:0] cfg_sum,
  input  logic              cfg_t1,
  input  logic              cfg_t2,
  input  logic              cfg_pin1,
  input  logic              cfg_pin2,
  input  logic              cfg_fb_raw,
  input  logic              cfg_comb,
  input  logic              cfg_act_high,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              fb_bur_t,
  output logic              fb_bur_c,
  output logic              fb_q1_t,
  output logic              fb_q1_c,
  output logic              fb_pin_t,
  output logic              fb_pin_c
);

  // Named internal events, exposed for the bound checker.
  logic d1_w, d2_w;
  logic q1_w, q2_w;
  logic clk1_w, clk2_w;
  logic rst1_w, rst2_w;

  mcell_sum_steer #(.TERMS(TERMS_PER_SUM), .GROUPS(SUM_GROUPS)) u_steer (
    .pt   (pt_data),
    .mode (cfg_sum),
    .sum1 (d1_w),
    .sum2 (d2_w)
  );

  logic [N_REG-1:0] ck_term, pin_sel, arst, t_mode, din, clk_eff, q;

  assign ck_term = {pt_ck2, pt_ck1};
  assign pin_sel = {cfg_pin2, cfg_pin1};
  assign arst    = {pt_ar2 | ~rst_n, pt_ar1 | ~rst_n};
  assign t_mode  = {cfg_t2, cfg_t1};
  assign din     = {d2_w, d1_w};

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    mcell_flop u_ff (
      .clk_term (ck_term[r]),
      .pin_clk  (pin_clk),
      .pin_sel  (pin_sel[r]),
      .arst     (arst[r]),
      .t_mode   (t_mode[r]),
      .preset   (sync_preset),
      .din      (din[r]),
      .clk_eff  (clk_eff[r]),
      .q        (q[r])
    );
  end

  assign q1_w   = q[0];
  assign q2_w   = q[1];
  assign clk1_w = clk_eff[0];
  assign clk2_w = clk_eff[1];
  assign rst1_w = arst[0];
  assign rst2_w = arst[1];

  logic bur_w, pad_val_w;

  assign bur_w     = cfg_fb_raw ? d2_w : q2_w;
  assign pad_val_w = cfg_comb ? d1_w : q1_w;

  assign pad_out  = cfg_act_high ? pad_val_w : ~pad_val_w;
  assign pad_oe   = pt_oe;
  assign fb_bur_t = bur_w;
  assign fb_bur_c = ~bur_w;
  assign fb_q1_t  = q1_w;
  assign fb_q1_c  = ~q1_w;
  assign fb_pin_t = pad_in;
  assign fb_pin_c = ~pad_in;

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk (
  input logic rst_n,
  input logic pin_clk,
  input logic clk1,
  input logic clk2,
  input logic rst1,
  input logic rst2,
  input logic q1,
  input logic q2,
  input logic d1,
  input logic d2,
  input logic preset,
  input logic t1,
  input logic t2,
  input logic comb,
  input logic act_high,
  input logic pad_out
);
  import mcell_pkg::*;

  // Armed once an effective edge has occurred since the last clear.
  logic arm1, arm2;

  always_ff @(posedge clk1 or posedge rst1) begin
    if (rst1) arm1 <= 1'b0;
    else      arm1 <= 1'b1;
  end

  always_ff @(posedge clk2 or posedge rst2) begin
    if (rst2) arm2 <= 1'b0;
    else      arm2 <= 1'b1;
  end

  AST_Q1_NEXT_STATE: assert property (@(posedge clk1) disable iff (rst1)
    arm1 |-> (q1 == ff_next($past(q1), $past(d1), $past(t1), $past(preset)))); // R7

  AST_Q2_NEXT_STATE: assert property (@(posedge clk2) disable iff (rst2)
    arm2 |-> (q2 == ff_next($past(q2), $past(d2), $past(t2), $past(preset)))); // R4

  AST_CLEAR_HOLDS_Q1: assert property (@(posedge clk1) disable iff (!rst_n)
    rst1 |-> !q1); // R6

  AST_PAD_TRACKS_REG: assert property (@(posedge pin_clk) disable iff (!rst_n)
    !comb |-> (pad_out == (act_high ? q1 : !q1))); // R9

endmodule

bind pld_mcell mcell_chk u_chk (
  .rst_n    (rst_n),
  .pin_clk  (pin_clk),
  .clk1     (clk1_w),
  .clk2     (clk2_w),
  .rst1     (rst1_w),
  .rst2     (rst2_w),
  .q1       (q1_w),
  .q2       (q2_w),
  .d1       (d1_w),
  .d2       (d2_w),
  .preset   (sync_preset),
  .t1       (cfg_t1),
  .t2       (cfg_t2),
  .comb     (cfg_comb),
  .act_high (cfg_act_high),
  .pad_out  (pad_out)
);

// File: tb/sim_pld_mcell.sv
module sim_pld_mcell;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pt_data = '0;
  logic        pt_ar1 = 0, pt_ck1 = 0, pt_ck2 = 0, pt_ar2 = 0, pt_oe = 0;
  logic        sync_preset = 0, pad_in = 0;
  logic [1:0]  cfg_sum = 2'd0;
  logic        cfg_t1 = 0, cfg_t2 = 0, cfg_pin1 = 0, cfg_pin2 = 0;
  logic        cfg_fb_raw = 0, cfg_comb = 0, cfg_act_high = 1;
  logic        pad_out, pad_oe, fb_bur_t, fb_bur_c, fb_q1_t, fb_q1_c, fb_pin_t, fb_pin_c;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pld_mcell u0 (
    .rst_n(rst_n), .pin_clk(clk), .pt_data(pt_data),
    .pt_ar1(pt_ar1), .pt_ck1(pt_ck1), .pt_ck2(pt_ck2), .pt_ar2(pt_ar2), .pt_oe(pt_oe),
    .sync_preset(sync_preset), .pad_in(pad_in), .cfg_sum(cfg_sum),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_pin1(cfg_pin1), .cfg_pin2(cfg_pin2),
    .cfg_fb_raw(cfg_fb_raw), .cfg_comb(cfg_comb), .cfg_act_high(cfg_act_high),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb_bur_t(fb_bur_t), .fb_bur_c(fb_bur_c),
    .fb_q1_t(fb_q1_t), .fb_q1_c(fb_q1_c), .fb_pin_t(fb_pin_t), .fb_pin_c(fb_pin_c)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Number of groups merged into register 1, counted from the setting.
  function automatic logic exp_sum1(input int mode, input logic [11:0] v);
    int used;
    logic acc;
    used = (mode >= 2) ? 3 : mode + 1;
    acc = 1'b0;
    for (int g = 0; g < used; g++) acc = acc | (((v >> (4 * g)) & 12'hF) != 0);
    return acc;
  endfunction

  function automatic logic exp_sum2(input logic [11:0] v);
    return (v / 256) != 0;
  endfunction

  task automatic pulse(input bit c1, input bit c2);
    #2;
    if (c1) pt_ck1 = 1'b1;
    if (c2) pt_ck2 = 1'b1;
    #2;
    pt_ck1 = 1'b0;
    pt_ck2 = 1'b0;
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic e1, e2, m1, m2;
    logic [11:0] v;

    #22;
    chk("R12 q1 in reset", fb_q1_t, 1'b0);
    rst_n = 1'b1;
    #3;
    chk("R12 q1 after reset", fb_q1_t, 1'b0);
    chk("R12 q2 after reset", fb_bur_t, 1'b0);
    chk("R12 pad active high", pad_out, 1'b0);
    cfg_act_high = 1'b0;
    #1;
    chk("R12 pad active low", pad_out, 1'b1);

    // Exhaustive combinational sweep: steering, bypass, polarity, pairs.
    cfg_comb = 1'b1;
    cfg_fb_raw = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int x = 0; x < 4096; x++) begin
          cfg_sum = 2'(m);
          cfg_act_high = pol[0];
          pt_data = 12'(x);
          #1;
          e1 = exp_sum1(m, 12'(x));
          e2 = exp_sum2(12'(x));
          chk("R1/R9 comb pad", pad_out, pol[0] ? e1 : !e1);
          chk("R2/R8 raw buried", fb_bur_t, e2);
          chk("R11 buried complement", fb_bur_c, !e2);
        end
      end
    end

    for (int b = 0; b < 4; b++) begin
      pad_in = b[0];
      pt_oe = b[1];
      #1;
      chk("R11 pin true", fb_pin_t, b[0]);
      chk("R11 pin comp", fb_pin_c, !b[0]);
      chk("R10 oe", pad_oe, b[1]);
    end

    // D mode, both registers, product-term clocks.
    cfg_comb = 1'b0;
    cfg_fb_raw = 1'b0;
    cfg_act_high = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cfg_sum = 2'(i % 4);
      v = 12'((i * 1103 + 77) % 4096);
      if (i % 7 == 0) v = 12'h000;
      pt_data = v;
      pulse(1, 1);
      e1 = exp_sum1(i % 4, v);
      chk("R3 d q1", fb_q1_t, e1);
      chk("R11 q1 comp", fb_q1_c, !e1);
      chk("R3 d q2", fb_bur_t, exp_sum2(v));
      chk("R9 reg pad", pad_out, e1);
    end

    // T mode with a reference model.
    cfg_t1 = 1'b1;
    cfg_t2 = 1'b1;
    m1 = fb_q1_t;
    m2 = fb_bur_t;
    for (int i = 0; i < 60; i++) begin
      cfg_sum = 2'(i % 3);
      v = 12'((i * 2731 + 5) % 4096);
      if (i % 5 == 0) v = 12'h000;
      pt_data = v;
      pulse(1, 1);
      m1 = m1 ^ exp_sum1(i % 3, v);
      m2 = m2 ^ exp_sum2(v);
      chk("R4 t q1", fb_q1_t, m1);
      chk("R4 t q2", fb_bur_t, m2);
    end

    // Separate clocks: only register 1 clocked.
    pt_data = 12'hFFF;
    pulse(1, 0);
    chk("R5 only q1 toggles", fb_q1_t, !m1);
    chk("R5 q2 held", fb_bur_t, m2);
    m1 = !m1;
    pulse(0, 1);
    chk("R5 q1 held", fb_q1_t, m1);
    chk("R5 only q2 toggles", fb_bur_t, !m2);
    m2 = !m2;

    // Pin-gated clock on register 1, D mode.
    cfg_t1 = 1'b0;
    cfg_t2 = 1'b0;
    cfg_sum = 2'd0;
    @(negedge clk);
    cfg_pin1 = 1'b1;
    pt_data = 12'h001;
    repeat (3) @(negedge clk);
    chk("R5 pin edges without term", fb_q1_t, m1);
    pt_ck1 = 1'b1;
    @(posedge clk);
    #2;
    chk("R5 term and pin load", fb_q1_t, 1'b1);
    @(negedge clk);
    pt_data = 12'h000;
    @(posedge clk);
    #2;
    chk("R5 next pin edge load", fb_q1_t, 1'b0);
    @(negedge clk);
    pt_ck1 = 1'b0;
    pt_data = 12'h001;
    repeat (2) @(negedge clk);
    chk("R5 gated off", fb_q1_t, 1'b0);
    cfg_pin1 = 1'b0;
    #1;

    // Asynchronous clears.
    pt_data = 12'hF0F;
    pulse(1, 1);
    chk("R6 setup q1", fb_q1_t, 1'b1);
    chk("R6 setup q2", fb_bur_t, 1'b1);
    pt_ar1 = 1'b1;
    #1;
    chk("R6 clear q1", fb_q1_t, 1'b0);
    chk("R6 q2 untouched", fb_bur_t, 1'b1);
    pt_ar1 = 1'b0;
    pt_ar2 = 1'b1;
    #1;
    chk("R6 clear q2", fb_bur_t, 1'b0);
    pt_ar2 = 1'b0;
    #1;

    // Synchronous preset over D and T data; clear over preset.
    pt_data = 12'h000;
    sync_preset = 1'b1;
    pulse(1, 1);
    chk("R7 preset q1 over d", fb_q1_t, 1'b1);
    chk("R7 preset q2 over d", fb_bur_t, 1'b1);
    cfg_t1 = 1'b1;
    pt_data = 12'h00F;
    pulse(1, 0);
    chk("R7 preset over toggle", fb_q1_t, 1'b1);
    pt_ar1 = 1'b1;
    pulse(1, 0);
    chk("R7 clear over preset", fb_q1_t, 1'b0);
    pt_ar1 = 1'b0;
    sync_preset = 1'b0;
    cfg_t1 = 1'b0;
    #1;

    // Bypass select with registered state differing from the sum input.
    pt_data = 12'h000;
    cfg_fb_raw = 1'b1;
    #1;
    chk("R8 raw shows sum", fb_bur_t, 1'b0);
    cfg_fb_raw = 1'b0;
    #1;
    chk("R8 reg shows q2", fb_bur_t, 1'b1);

    // Power-up reset mid-run.
    rst_n = 1'b0;
    #1;
    chk("R12 reset clears q2", fb_bur_t, 1'b0);
    chk("R12 reset clears q1", fb_q1_t, 1'b0);
    rst_n = 1'b1;
    #10;
    finish_run();
  end

endmodule